// File: doc/BRIEF.md
# Atomic Link/Swap Memory Unit

This block sits in front of a single-ported word memory that several requesters share. It serves one request per clock and chooses among requesters by fixed priority. It offers three atomic primitives on top of the memory. A linked load reads a word and arms a per-requester reservation on its address. A conditional store writes only while that reservation is still intact, and it reports whether the write happened. A swap returns the old word and writes a new one in the same granted cycle.

Software builds locks and read-modify-write loops from these primitives. A lock is taken when a swap of a nonzero value returns zero. It is released with a plain store of zero. A linked-load / conditional-store loop retries whenever the conditional store reports failure. A reservation is lost when another requester writes the reserved address, when a reservation is newly armed, or when the owner attempts a conditional store. Requests arriving in the same cycle are ordered by requester index, and that ordering also decides which reservations survive.

Top module: `amu_top`

## Requirements
- R1: While reset is held and after its release, no response is presented and every requester's reservation is invalid, so a conditional store issued before any linked load fails.
- R2: Opcode 2'b00 (linked load) returns the memory word at the address in the response of the following cycle with status 1, and arms that requester's reservation on the address.
- R3: Opcode 2'b01 (conditional store) with a valid reservation on the same address writes the data, returns status 1 and clears the requester's own reservation, so a repeat without a new linked load fails.
- R4: A conditional store without a valid reservation, or with a reservation on a different address, leaves memory unchanged and returns status 0.
- R5: A write to an address (plain store, swap, or successful conditional store) by one requester invalidates every other requester's reservation on that address. Reservations on other addresses are kept.
- R6: Opcode 2'b10 (swap) returns the word held before the operation and writes the new data within the same grant, with status 1.
- R7: Opcode 2'b11 (plain store) writes unconditionally with status 1. Storing zero to a lock word taken by a swap that returned zero lets the next swap return zero again.
- R8: At most one requester is granted per cycle: the lowest-indexed one with a valid request. Its response appears on the next cycle and carries its index.
- R9: When conflicting requests arrive in the same cycle, reservations are broken in grant order. A conditional store granted before a store to its address succeeds. One granted after such a store fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Per-requester request, held until granted |
| req_op | input | 2*N | Per-requester opcode (2'b00 link load, 2'b01 cond. store, 2'b10 swap, 2'b11 store) |
| req_addr | input | AW*N | Per-requester word address |
| req_wdata | input | DW*N | Per-requester write data |
| grant | output | N | One-hot grant for the current cycle |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | IW | Index of the requester being answered |
| rsp_rdata | output | DW | Word read before any write by the operation |
| rsp_status | output | 1 | 1 on success, 0 on a failed conditional store |

## Verification
The bench builds the block with three requesters, a 16-word memory and 16-bit words. The small address space lets the tests aim different requesters at one word on purpose. Three requesters are enough to post a conditional store and a conflicting store in the same cycle from either side of the priority order. In that configuration each reservation-breaking order, and each outcome of the lock handshake, can be reached with a few directed operations.

// File: rtl/amu_pkg.sv
package amu_pkg;

  typedef enum logic [1:0] {
    OP_LINK_LD = 2'b00,
    OP_COND_ST = 2'b01,
    OP_SWAP    = 2'b10,
    OP_STORE   = 2'b11
  } amu_op_e;

  // Whether a granted operation modifies memory.
  function automatic logic op_writes(input amu_op_e op, input logic resv_ok);
    return (op == OP_SWAP) || (op == OP_STORE) || ((op == OP_COND_ST) && resv_ok);
  endfunction

  // Status reported back for a granted operation.
  function automatic logic op_status(input amu_op_e op, input logic resv_ok);
    return (op != OP_COND_ST) || resv_ok;
  endfunction

endpackage

// File: rtl/amu_prio_arb.sv
module amu_prio_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_id,
  output logic          gnt_any
);
  always_comb begin
    gnt     = '0;
    gnt_id  = '0;
    gnt_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !gnt_any) begin
        gnt[i]  = 1'b1;
        gnt_id  = IW'(i);
        gnt_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/amu_link_table.sv
module amu_link_table
  import amu_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_id,
  input  amu_op_e       upd_op,
  input  logic [AW-1:0] upd_addr,
  input  logic          wr_commit,
  output logic [N-1:0]  link_valid,
  output logic          own_hit
);
  logic [N-1:0] addr_hit;
  logic [N-1:0] own_sel;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_link
      logic [AW-1:0] link_addr;
      assign addr_hit[g] = link_valid[g] && (link_addr == upd_addr);
      assign own_sel[g]  = (upd_id == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          link_valid[g] <= 1'b0;
          link_addr     <= '0;
        end else if (upd_en) begin
          if (own_sel[g]) begin
            if (upd_op == OP_LINK_LD) begin
              link_valid[g] <= 1'b1;
              link_addr     <= upd_addr;
            end else if (upd_op == OP_COND_ST) begin
              link_valid[g] <= 1'b0;
            end
          end else if (wr_commit && addr_hit[g]) begin
            link_valid[g] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  assign own_hit = |(addr_hit & own_sel);
endmodule

// File: rtl/amu_word_mem.sv
module amu_word_mem #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_old
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  assign rdata_old = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/amu_top.sv
module amu_top
  import amu_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [2*N-1:0]  req_op,
  input  logic [AW*N-1:0] req_addr,
  input  logic [DW*N-1:0] req_wdata,
  output logic [N-1:0]    grant,
  output logic            rsp_valid,
  output logic [IW-1:0]   rsp_id,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_status
);
  logic [IW-1:0] gnt_id;
  logic          gnt_any;
  amu_op_e       sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic          own_hit;
  logic [N-1:0]  link_valid;
  logic [DW-1:0] old_word;
  logic          mem_we;
  logic          sc_pass;
  logic          sc_fail;

  amu_prio_arb #(.N(N), .IW(IW)) arb_i (
    .req(req_valid), .gnt(grant), .gnt_id(gnt_id), .gnt_any(gnt_any)
  );

  always_comb begin
    sel_op    = amu_op_e'(req_op[gnt_id*2 +: 2]);
    sel_addr  = req_addr[gnt_id*AW +: AW];
    sel_wdata = req_wdata[gnt_id*DW +: DW];
  end

  assign mem_we  = gnt_any && op_writes(sel_op, own_hit);
  assign sc_pass = gnt_any && (sel_op == OP_COND_ST) && own_hit;
  assign sc_fail = gnt_any && (sel_op == OP_COND_ST) && !own_hit;

  amu_link_table #(.N(N), .IW(IW), .AW(AW)) links_i (
    .clk(clk), .rst_n(rst_n), .upd_en(gnt_any), .upd_id(gnt_id),
    .upd_op(sel_op), .upd_addr(sel_addr), .wr_commit(mem_we),
    .link_valid(link_valid), .own_hit(own_hit)
  );

  amu_word_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .we(mem_we), .addr(sel_addr), .wdata(sel_wdata), .rdata_old(old_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_id     <= '0;
      rsp_rdata  <= '0;
      rsp_status <= 1'b0;
    end else begin
      rsp_valid <= gnt_any;
      if (gnt_any) begin
        rsp_id     <= gnt_id;
        rsp_rdata  <= old_word;
        rsp_status <= op_status(sel_op, own_hit);
      end
    end
  end
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_valid,
  input logic [N-1:0]  grant,
  input logic          rsp_valid,
  input logic          rsp_status,
  input logic          mem_we,
  input logic          sc_pass,
  input logic          sc_fail,
  input logic [N-1:0]  link_valid,
  input logic [IW-1:0] gnt_id
);
  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);
  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |=> rsp_valid);
  assert_fail_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fail |-> !mem_we);
  assert_status_zero_only_on_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_status) |-> $past(sc_fail));
  assert_pass_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> mem_we);
  assert_pass_clears_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |=> !link_valid[$past(gnt_id)]);
  assert_reset_clears_links_R1: assert property (@(posedge clk)
    !rst_n |=> (link_valid == '0));
endmodule

bind amu_top amu_checker #(.N(N), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .grant(grant),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .mem_we(mem_we),
  .sc_pass(sc_pass), .sc_fail(sc_fail), .link_valid(link_valid), .gnt_id(gnt_id)
);

// File: tb/amu_top_tb_top.sv
module amu_top_tb_top;
  localparam int N  = 3;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam logic [1:0] LL = 2'b00, SC = 2'b01, SW = 2'b10, ST = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    grant;
  logic            rsp_valid;
  logic [IW-1:0]   rsp_id;
  logic [DW-1:0]   rsp_rdata;
  logic            rsp_status;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  amu_top #(.N(N), .AW(AW), .DW(DW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input int id, input logic [1:0] op, input int a, input int wd);
    req_op[id*2 +: 2]     = op;
    req_addr[id*AW +: AW] = AW'(a);
    req_wdata[id*DW +: DW] = DW'(wd);
    req_valid[id]         = 1'b1;
  endtask

  // One request by one requester; returns old word and status.
  task automatic issue(input int id, input logic [1:0] op, input int a, input int wd,
                       output int rd, output bit st);
    @(negedge clk);
    set_req(id, op, a, wd);
    #2;
    chk(grant == N'(1 << id), "R8 grant", grant, 1 << id);
    @(negedge clk);
    chk(rsp_valid && rsp_id == IW'(id), "R8 rsp id", rsp_id, id);
    rd = rsp_rdata;
    st = rsp_status;
    req_valid[id] = 1'b0;
  endtask

  task automatic t_reset;
    int rd; bit st;
    chk(rsp_valid == 1'b0, "R1 no rsp in reset", rsp_valid, 0);
    chk(grant == '0, "R1 no grant in reset", grant, 0);
    @(negedge clk); rst_n = 1'b1;
    issue(1, SC, 3, 16'h1234, rd, st);
    chk(st == 1'b0, "R1 cond store before link fails", st, 0);
  endtask

  task automatic t_link_and_cond;
    int rd; bit st;
    issue(0, ST, 3, 16'h00A5, rd, st);
    chk(st == 1'b1, "R7 store status", st, 1);
    issue(0, LL, 3, 0, rd, st);
    chk(rd == 16'h00A5 && st, "R2 linked load data", rd, 16'h00A5);
    issue(0, SC, 3, 16'h0B0B, rd, st);
    chk(st == 1'b1, "R3 cond store succeeds", st, 1);
    issue(0, SC, 3, 16'h0C0C, rd, st);
    chk(st == 1'b0, "R3 repeat cond store fails", st, 0);
    issue(0, LL, 3, 0, rd, st);
    chk(rd == 16'h0B0B, "R4 failed store left memory", rd, 16'h0B0B);
    issue(0, SC, 4, 16'h7777, rd, st);
    chk(st == 1'b0, "R4 address mismatch fails", st, 0);
    issue(1, LL, 4, 0, rd, st);
    chk(rd != 16'h7777, "R4 mismatched address not written", rd, 0);
  endtask

  task automatic t_break;
    int rd; bit st;
    issue(0, LL, 7, 0, rd, st);
    issue(1, ST, 7, 16'h0101, rd, st);
    issue(0, SC, 7, 16'h0202, rd, st);
    chk(st == 1'b0, "R5 other store breaks link", st, 0);
    issue(0, LL, 7, 0, rd, st);
    issue(2, SW, 7, 16'h0303, rd, st);
    issue(0, SC, 7, 16'h0404, rd, st);
    chk(st == 1'b0, "R5 other swap breaks link", st, 0);
    issue(0, LL, 7, 0, rd, st);
    issue(1, ST, 8, 16'h0505, rd, st);
    issue(0, SC, 7, 16'h0606, rd, st);
    chk(st == 1'b1, "R5 unrelated address keeps link", st, 1);
  endtask

  task automatic t_swap_lock;
    int rd; bit st;
    issue(0, ST, 9, 16'h0000, rd, st);
    issue(0, SW, 9, 16'h0001, rd, st);
    chk(rd == 0 && st, "R6 swap returns old zero", rd, 0);
    issue(1, SW, 9, 16'h0001, rd, st);
    chk(rd == 1, "R6 swap sees held lock", rd, 1);
    issue(0, ST, 9, 16'h0000, rd, st);
    issue(1, SW, 9, 16'h0001, rd, st);
    chk(rd == 0, "R7 zero store released lock", rd, 0);
    issue(2, SW, 10, 16'h00EE, rd, st);
    issue(2, SW, 10, 16'h00FF, rd, st);
    chk(rd == 16'h00EE, "R6 swap wrote new word", rd, 16'h00EE);
  endtask

  task automatic t_arbitration;
    int rd; bit st;
    issue(0, ST, 11, 16'h1111, rd, st);
    issue(0, ST, 12, 16'h2222, rd, st);
    issue(0, ST, 13, 16'h3333, rd, st);
    @(negedge clk);
    set_req(0, LL, 11, 0); set_req(1, LL, 12, 0); set_req(2, LL, 13, 0);
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(grant == N'(1 << k), "R8 priority grant", grant, 1 << k);
      @(negedge clk);
      chk(rsp_valid && rsp_id == IW'(k), "R8 response order", rsp_id, k);
      chk(rsp_rdata == DW'(16'h1111 * (k + 1)), "R8 response data", rsp_rdata, 16'h1111 * (k + 1));
      req_valid[k] = 1'b0;
    end
  endtask

  task automatic t_same_cycle;
    int rd; bit st;
    issue(0, LL, 5, 0, rd, st);
    @(negedge clk);
    set_req(0, SC, 5, 16'h0011); set_req(1, ST, 5, 16'h0022);
    @(negedge clk);
    chk(rsp_id == 0 && rsp_status, "R9 higher priority cond store wins", rsp_status, 1);
    req_valid[0] = 1'b0;
    @(negedge clk);
    req_valid[1] = 1'b0;
    issue(2, LL, 5, 0, rd, st);
    chk(rd == 16'h0022, "R9 later store lands last", rd, 16'h0022);
    issue(2, LL, 6, 0, rd, st);
    @(negedge clk);
    set_req(1, ST, 6, 16'h0044); set_req(2, SC, 6, 16'h0055);
    @(negedge clk);
    req_valid[1] = 1'b0;
    @(negedge clk);
    chk(rsp_id == 2 && !rsp_status, "R9 store first breaks lower link", rsp_status, 0);
    req_valid[2] = 1'b0;
    issue(0, LL, 6, 0, rd, st);
    chk(rd == 16'h0044, "R9 failed cond store not written", rd, 16'h0044);
  endtask

  initial begin
    #1;
    t_reset();
    t_link_and_cond();
    t_break();
    t_swap_lock();
    t_arbitration();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule